// File: doc/BRIEF.md
# Odd/Even Pixel Pair Splitter

This block sits between a pixel source and a pair of serializers. It takes one pixel per clock. Each pixel is a word of colour bits topped by the three sync bits: horizontal sync, vertical sync and data-enable. A 2-bit mode input chooses how the pixels reach the two output ports. In single mode, port A carries the stream unchanged. In dual mode, a second colour input is passed to port B at the same rate, and port B shares port A's sync bits. In split mode, the stream is divided into pairs. The first pixel of a pair goes to port A and the second to port B, and both ports update together on a half-rate enable.

In split mode the pairing restarts on every rising edge of data-enable, so the first active pixel of a line always lands on port A. Blanking intervals must be an even number of cycles long. When data-enable rises while the pairing counter expects the second pixel of a pair, the block raises a one-cycle phase error. It then treats that pixel as the first of a new pair. The unused mode code behaves like single mode and raises a configuration-error output.

All outputs are registered. Each output appears one clock after the input that produced it. In split mode, the pair appears one clock after its second pixel.

Top module: `pixel_pair_splitter`

## Requirements
- R1: While reset is asserted (rst_n low), both output words, out_valid, out_b_en, phase_err and cfg_err are all zero.
- R2: In mode 2'b00, out_a_word equals the in_a_word of the previous cycle. out_valid is 1 every cycle, out_b_word is zero and out_b_en is 0. Word layout: bit COLOR_W+2 is DE, bit COLOR_W+1 is VS, bit COLOR_W is HS, and the bits below COLOR_W are colour.
- R3: In mode 2'b10, out_a_word equals the previous in_a_word. out_b_word is the previous in_b_color with the previous in_a_word's three sync bits above it. out_valid and out_b_en are 1 every cycle.
- R4: In mode 2'b01, the pixel sampled in the cycle of a DE rise, and every second pixel after it, goes to out_a_word. Its successor goes to out_b_word. Both appear, with out_valid high, in the cycle after the successor is sampled.
- R5: In mode 2'b01, out_valid is never high in two consecutive cycles. Between pairs, the output words hold their values.
- R6: In mode 2'b01, the sync bits of out_b_word are copied from the first pixel of the pair, not from the second.
- R7: In mode 2'b01, a DE rise sampled when the pairing would send that pixel to port B raises phase_err for exactly the next cycle. No pair is presented in that cycle, and that pixel becomes the port-A pixel of the next pair.
- R8: Mode 2'b11 behaves exactly like mode 2'b00, and cfg_err is 1 in the cycle after each cycle sampled in that mode.
- R9: In mode 2'b01, in_b_color is ignored. The colour bits of out_b_word come from in_a_word.
- R10: On entry into mode 2'b01, the first pixel sampled in that mode goes to port A even without a DE rise. out_b_en is 1 while in split mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 single, 01 split, 10 dual, 11 unused |
| in_a_word | input | COLOR_W+3 | Primary pixel: DE, VS, HS, colour |
| in_b_color | input | COLOR_W | Second colour input, used in dual mode |
| out_a_word | output | COLOR_W+3 | Port A pixel |
| out_b_word | output | COLOR_W+3 | Port B pixel |
| out_valid | output | 1 | Output words are new this cycle |
| out_b_en | output | 1 | Port B carries pixels |
| phase_err | output | 1 | Odd-length blanking detected |
| cfg_err | output | 1 | Unused mode code selected |

## Verification
Two events can land on the same clock: a DE rise that falls on the port-B slot, and the presentation of a pair. The bench provokes the collision with a three-cycle blanking gap. It then checks that the realignment wins: phase_err is high, out_valid is low, and the stray pixel heads the next pair on port A. A second overlap is a mode switch into split mode while DE stays high. Here the pairing must restart from the switch itself rather than from a DE rise. A behavioural model compares every output on every clock.

// File: rtl/pps_pkg.sv
package pps_pkg;
   typedef enum logic [1:0] {
      MODE_SINGLE = 2'b00,
      MODE_SPLIT  = 2'b01,
      MODE_DUAL   = 2'b10,
      MODE_RESV   = 2'b11
   } pps_mode_e;

   localparam int SYNC_W = 3;
endpackage

// File: rtl/pps_phase_track.sv
module pps_phase_track (
   input  logic clk,
   input  logic rst_n,
   input  logic split_en,
   input  logic de_in,
   output logic odd_slot,
   output logic slip
);
   logic de_prev;
   logic phase_q;

   assign slip     = split_en & phase_q & de_in & ~de_prev;
   assign odd_slot = ~phase_q | slip;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         de_prev <= 1'b0;
         phase_q <= 1'b0;
      end else begin
         de_prev <= de_in;
         phase_q <= split_en & odd_slot;
      end
   end

   // R10: leaving split mode leaves the pairing at the port-A slot
   a_r10_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !split_en |=> odd_slot);
endmodule

// File: rtl/pps_word_reg.sv
module pps_word_reg #(
   parameter int WIDTH = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("pps_word_reg: WIDTH must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/pixel_pair_splitter.sv
module pixel_pair_splitter #(
   parameter int COLOR_W = 25
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode,
   input  logic [COLOR_W+2:0] in_a_word,
   input  logic [COLOR_W-1:0] in_b_color,
   output logic [COLOR_W+2:0] out_a_word,
   output logic [COLOR_W+2:0] out_b_word,
   output logic               out_valid,
   output logic               out_b_en,
   output logic               phase_err,
   output logic               cfg_err
);
   import pps_pkg::*;

   localparam int WORD_W = COLOR_W + SYNC_W;
   localparam int DE_BIT = WORD_W - 1;

   if (COLOR_W < 1) begin : g_bad_color
      $error("pixel_pair_splitter: COLOR_W must be positive");
   end

   pps_mode_e   sel;
   logic        split_en, odd_slot, slip, load;
   logic [WORD_W-1:0] odd_q, nxt_a, nxt_b;

   assign sel      = pps_mode_e'(mode);
   assign split_en = (sel == MODE_SPLIT);

   pps_phase_track u_track (
      .clk(clk), .rst_n(rst_n), .split_en(split_en),
      .de_in(in_a_word[DE_BIT]), .odd_slot(odd_slot), .slip(slip)
   );

   pps_word_reg #(.WIDTH(WORD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(split_en & odd_slot),
      .d(in_a_word), .q(odd_q)
   );

   always_comb begin
      unique case (sel)
         MODE_SPLIT: begin
            load  = ~odd_slot;
            nxt_a = odd_q;
            nxt_b = {odd_q[WORD_W-1 -: SYNC_W], in_a_word[COLOR_W-1:0]};
         end
         MODE_DUAL: begin
            load  = 1'b1;
            nxt_a = in_a_word;
            nxt_b = {in_a_word[WORD_W-1 -: SYNC_W], in_b_color};
         end
         default: begin
            load  = 1'b1;
            nxt_a = in_a_word;
            nxt_b = '0;
         end
      endcase
   end

   pps_word_reg #(.WIDTH(WORD_W)) u_out_a (
      .clk(clk), .rst_n(rst_n), .load(load), .d(nxt_a), .q(out_a_word)
   );

   pps_word_reg #(.WIDTH(WORD_W)) u_out_b (
      .clk(clk), .rst_n(rst_n), .load(load), .d(nxt_b), .q(out_b_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_b_en  <= 1'b0;
         phase_err <= 1'b0;
         cfg_err   <= 1'b0;
      end else begin
         out_valid <= load;
         out_b_en  <= (sel == MODE_SPLIT) | (sel == MODE_DUAL);
         phase_err <= slip;
         cfg_err   <= (sel == MODE_RESV);
      end
   end

   // R5: steady split mode never presents two pairs back to back
   a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'b01 && $past(mode, 2) == 2'b01) |-> !(out_valid && $past(out_valid)));

   // R7: a realignment cycle never presents a pair
   a_r7_err_no_present: assert property (@(posedge clk) disable iff (!rst_n)
      phase_err |-> !out_valid);

   // R6: whenever port B carries a fresh word, its sync matches port A
   a_r6_sync_shared: assert property (@(posedge clk) disable iff (!rst_n)
      (out_b_en && out_valid) |-> out_b_word[WORD_W-1 -: SYNC_W] == out_a_word[WORD_W-1 -: SYNC_W]);

   // R8: the unused code acts as single mode
   a_r8_cfg_single: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!out_b_en && out_valid));

   // R2: outside split mode every cycle is presented
   a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode) != 2'b01) |-> out_valid);
endmodule

// File: tb/pixel_pair_splitter_bench.sv
module pixel_pair_splitter_bench;
   localparam int CW = 25;
   localparam int WW = CW + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [WW-1:0] in_a_word = '0;
   logic [CW-1:0] in_b_color = '0;
   logic [WW-1:0] out_a_word, out_b_word;
   logic out_valid, out_b_en, phase_err, cfg_err;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pixel_pair_splitter #(.COLOR_W(CW)) u_pixel_pair_splitter (
      .clk(clk), .rst_n(rst_n), .mode(mode), .in_a_word(in_a_word),
      .in_b_color(in_b_color), .out_a_word(out_a_word), .out_b_word(out_b_word),
      .out_valid(out_valid), .out_b_en(out_b_en), .phase_err(phase_err),
      .cfg_err(cfg_err)
   );

   // behavioural reference
   logic [WW-1:0] e_a, e_b, hold;
   bit e_valid, e_b_en, e_cfg, e_perr, pde, second_slot, prev_split, split2, first_pair;
   bit tag_r10;
   int e_mode;

   always @(posedge clk) begin
      if (!rst_n) begin
         e_a = '0; e_b = '0; hold = '0; e_valid = 0; e_b_en = 0; e_cfg = 0;
         e_perr = 0; pde = 0; second_slot = 0; prev_split = 0; split2 = 0;
         first_pair = 0; tag_r10 = 0; e_mode = 0;
      end else begin
         e_mode = mode;
         e_cfg  = (mode == 2'b11);
         e_b_en = (mode == 2'b01) || (mode == 2'b10);
         e_perr = 0;
         split2 = prev_split && (mode == 2'b01);
         if (mode == 2'b01) begin
            if (!prev_split) first_pair = 1;
            if (second_slot && in_a_word[WW-1] && !pde) begin
               e_perr = 1;
               second_slot = 0;
               first_pair = 0;
            end
            if (!second_slot) begin
               hold = in_a_word;
               e_valid = 0;
               second_slot = 1;
            end else begin
               e_a = hold;
               e_b = {hold[WW-1 -: 3], in_a_word[CW-1:0]};
               e_valid = 1;
               tag_r10 = first_pair;
               first_pair = 0;
               second_slot = 0;
            end
            prev_split = 1;
         end else begin
            second_slot = 0;
            prev_split = 0;
            e_valid = 1;
            e_a = in_a_word;
            e_b = (mode == 2'b10) ? {in_a_word[WW-1 -: 3], in_b_color} : '0;
         end
         pde = in_a_word[WW-1];
      end
   end

   task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   bit last_valid;
   always @(negedge clk) begin
      if (!rst_n) begin
         cmp("R1 outputs", {out_a_word, out_b_word} == '0 ? 64'd0 : 64'd1, 64'd0);
         cmp("R1 flags", {out_valid, out_b_en, phase_err, cfg_err}, 64'd0);
         last_valid = 0;
      end else begin
         case (e_mode)
            0: begin
               cmp("R2 port A", out_a_word, e_a);
               cmp("R2 port B", out_b_word, e_b);
               cmp("R2 valid", out_valid, e_valid);
            end
            2: begin
               cmp("R3 port A", out_a_word, e_a);
               cmp("R3 port B", out_b_word, e_b);
               cmp("R3 valid", out_valid, e_valid);
            end
            3: begin
               cmp("R8 port A", out_a_word, e_a);
               cmp("R8 port B", out_b_word, e_b);
            end
            default: begin
               cmp(tag_r10 ? "R10 first pair port A" : "R4 port A", out_a_word, e_a);
               cmp("R6 port B sync", out_b_word[WW-1 -: 3], e_b[WW-1 -: 3]);
               cmp("R9 port B colour", out_b_word[CW-1:0], e_b[CW-1:0]);
               cmp("R4 valid", out_valid, e_valid);
               if (split2) cmp("R5 back to back", out_valid && last_valid, 1'b0);
            end
         endcase
         cmp("R10 port B enable", out_b_en, e_b_en);
         cmp("R7 phase error", phase_err, e_perr);
         cmp("R8 config error", cfg_err, e_cfg);
         last_valid = out_valid;
      end
   end

   task automatic pix(input bit de);
      @(posedge clk); #1;
      in_a_word = {de, 2'($urandom), CW'($urandom)};
      in_b_color = CW'($urandom);
   endtask

   task automatic frame(input int blank, input int active);
      for (int i = 0; i < blank; i++) pix(1'b0);
      for (int i = 0; i < active; i++) pix(1'b1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      mode = 2'b00;
      frame(3, 12);
      mode = 2'b11;
      frame(2, 8);
      mode = 2'b10;
      frame(4, 14);
      mode = 2'b01;
      frame(4, 6);
      frame(4, 8);
      frame(3, 4);       // odd blanking: R7 collision with a pair slot
      frame(2, 6);
      frame(5, 7);
      mode = 2'b00;
      frame(2, 3);
      mode = 2'b01;      // R10: entry while DE stays high
      frame(0, 9);
      frame(2, 5);
      mode = 2'b10;
      frame(1, 4);
      pix(1'b0);
      pix(1'b0);
      @(posedge clk);
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule